// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block watches the request/acknowledge port between a load/store unit and the memory-side buffer that serves it. It is passive: none of its outputs feed back into the handshake. Its one exception is `busy_o`, which it drives for the port. `busy_o` goes high when a new load or store request appears. It goes low on the cycle that matches how the transfer ends.

Every cycle the monitor compares the port against the handshake rules. Each broken rule sets its own bit in a sticky error vector. A bit stays set until software-independent logic pulses `clr_i` or reset is applied. An `abort_i` pulse cancels the transfer in progress.

The port carries no streaming data path, so there is no valid/ready flow control and no back-pressure. Every pin is a plain control or status level, sampled on the rising clock edge.

Top module: `lsport_monitor`

## Requirements
- R1: If `ld_req_i` and `st_req_i` are high in the same cycle, error bit 0 is set on the following cycle.
- R2: A rising edge on the OR of the two request strobes, seen while no transfer is active, raises `busy_o` in that same cycle (combinationally). `busy_o` then stays high until the transfer completes or is aborted.
- R3: A rising request edge while a transfer is already active sets error bit 1. It does not start a second transfer.
- R4: The address is held from the first cycle of a transfer in which `adr_vld_i` is seen high. In every later cycle in which the transfer is active, dropping `adr_vld_i` or changing `adr_i` sets error bit 2.
- R5: `adr_ack_i` high for two consecutive cycles sets error bit 3. `adr_exc_i` high for two consecutive cycles sets error bit 4.
- R6: `adr_ack_i` and `adr_exc_i` high together sets error bit 5.
- R7: `busy_o` is low in any cycle in which `adr_exc_i` is high, and the transfer ends.
- R8: During a load, `busy_o` is low in the cycle `ld_vld_i` is high. `ld_vld_i` high for two consecutive cycles sets bit 6. `ld_vld_i` high outside an active load sets bit 7.
- R9: `st_vld_i` sets bit 8 unless a store is active and `adr_ack_i` pulsed in an earlier cycle of that store. `st_vld_i` high for two consecutive cycles sets bit 9. `busy_o` stays high in the `st_vld_i` cycle and is low in the next cycle, unless a new request edge arrives in that next cycle.
- R10: Error bits are sticky. A `clr_i` pulse clears all bits at the next edge, and it wins over a violation in the same cycle. Every error bit appears one cycle after its violation.
- R11: `busy_o` is low while `abort_i` is high. The monitor is idle in the next cycle, so `busy_o` stays low there unless a new request edge arrives.
- R12: Reset (`rst_n` low, asynchronous) forces `busy_o` low and clears every error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all error bits |
| abort_i | input | 1 | Cancel the transfer in progress |
| ld_req_i | input | 1 | Load request strobe |
| st_req_i | input | 1 | Store request strobe |
| adr_vld_i | input | 1 | Address valid |
| adr_i | input | AW | Transfer address |
| adr_ack_i | input | 1 | Address-accepted pulse from the buffer |
| adr_exc_i | input | 1 | Address-exception pulse from the buffer |
| ld_vld_i | input | 1 | Load data valid pulse |
| st_vld_i | input | 1 | Store data valid pulse |
| busy_o | output | 1 | Port busy |
| err_o | output | 10 | Sticky rule-violation flags, bit n as listed in the requirements |

## Verification
The hardest case to reach is a request edge during an active transfer (R3). The requester has to drop its strobe and raise it again while no completion event has yet arrived. The stimulus does this by issuing both strobes together, releasing them for one cycle, and then re-raising the load strobe. A second case is `st_vld_i` in the cycle after the store has already ended. To reach it, the stimulus holds `st_vld_i` for two cycles, so one violation sets both the early-data flag and the pulse-width flag. A third case is a clear pulse landing on a violation in the same cycle; it is reached by raising both strobes together while `clr_i` is high.

// File: rtl/lspm_pkg.sv
`timescale 1ns/1ps
package lspm_pkg;
  // error vector layout
  localparam int N_RULES    = 10;
  localparam int R_BOTH     = 0;
  localparam int R_REQBUSY  = 1;
  localparam int R_ADRMOVE  = 2;
  localparam int R_ACKLONG  = 3;
  localparam int R_EXCLONG  = 4;
  localparam int R_ACKEXC   = 5;
  localparam int R_LDLONG   = 6;
  localparam int R_LDSTRAY  = 7;
  localparam int R_STEARLY  = 8;
  localparam int R_STLONG   = 9;
  // single-cycle event vector layout
  localparam int N_EVT  = 4;
  localparam int EV_ACK = 0;
  localparam int EV_EXC = 1;
  localparam int EV_LD  = 2;
  localparam int EV_ST  = 3;
endpackage

// File: rtl/lspm_pulse_hist.sv
`timescale 1ns/1ps
// One-cycle history of each event line, used for pulse-width rules.
module lspm_pulse_hist #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o[g] <= 1'b0;
      else        prev_o[g] <= cur_i[g];
    end
  end
endmodule

// File: rtl/lspm_xfer.sv
`timescale 1ns/1ps
// Transfer tracker: owns busy and the per-transfer context.
module lspm_xfer #(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          ld_req_i,
  input  logic          st_req_i,
  input  logic          adr_vld_i,
  input  logic [AW-1:0] adr_i,
  input  logic          adr_ack_i,
  input  logic          adr_exc_i,
  input  logic          ld_vld_i,
  input  logic          st_vld_i,
  output logic          busy_o,
  output logic          act_o,
  output logic          live_o,
  output logic          kind_st_o,
  output logic          ackd_o,
  output logic          held_o,
  output logic [AW-1:0] adr_hold_o,
  output logic          req_edge_o
);
  logic          req_q, act_q, st_q, ackd_q, held_q;
  logic [AW-1:0] adr_q;
  logic          req_any, start, live, kind_st, end_now, busy, act_d;

  always_comb begin
    req_any    = ld_req_i | st_req_i;
    req_edge_o = req_any & ~req_q;
    start      = req_edge_o & ~act_q;
    live       = act_q | start;
    kind_st    = act_q ? st_q : st_req_i;
    // exception and load data end the transfer in their own cycle
    end_now    = adr_exc_i | (ld_vld_i & ~kind_st);
    busy       = live & ~end_now & ~abort_i;
    // store data ends it one cycle later
    act_d      = busy & ~st_vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      act_q  <= 1'b0;
      st_q   <= 1'b0;
      ackd_q <= 1'b0;
      held_q <= 1'b0;
      adr_q  <= '0;
    end else begin
      req_q  <= req_any;
      act_q  <= act_d;
      if (start) st_q <= st_req_i;
      ackd_q <= act_d & (ackd_q | (adr_ack_i & live));
      held_q <= act_d & (held_q | (adr_vld_i & live));
      if (live & adr_vld_i & ~held_q) adr_q <= adr_i;
    end
  end

  assign busy_o     = busy;
  assign act_o      = act_q;
  assign live_o     = live;
  assign kind_st_o  = kind_st;
  assign ackd_o     = ackd_q;
  assign held_o     = held_q;
  assign adr_hold_o = adr_q;
endmodule

// File: rtl/lspm_rules.sv
`timescale 1ns/1ps
// Combinational rule evaluation, one hit line per rule.
module lspm_rules
  import lspm_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic               ld_req_i,
  input  logic               st_req_i,
  input  logic               req_edge_i,
  input  logic               act_i,
  input  logic               live_i,
  input  logic               kind_st_i,
  input  logic               ackd_i,
  input  logic               held_i,
  input  logic               adr_vld_i,
  input  logic [AW-1:0]      adr_i,
  input  logic [AW-1:0]      adr_hold_i,
  input  logic [N_EVT-1:0]   evt_i,
  input  logic [N_EVT-1:0]   evt_prev_i,
  output logic [N_RULES-1:0] hit_o
);
  logic [N_EVT-1:0] twice;
  assign twice = evt_i & evt_prev_i;

  always_comb begin
    hit_o            = '0;
    hit_o[R_BOTH]    = ld_req_i & st_req_i;
    hit_o[R_REQBUSY] = req_edge_i & act_i;
    hit_o[R_ADRMOVE] = act_i & held_i & (~adr_vld_i | (adr_i != adr_hold_i));
    hit_o[R_ACKLONG] = twice[EV_ACK];
    hit_o[R_EXCLONG] = twice[EV_EXC];
    hit_o[R_ACKEXC]  = evt_i[EV_ACK] & evt_i[EV_EXC];
    hit_o[R_LDLONG]  = twice[EV_LD];
    hit_o[R_LDSTRAY] = evt_i[EV_LD] & ~(live_i & ~kind_st_i);
    hit_o[R_STEARLY] = evt_i[EV_ST] & ~(act_i & kind_st_i & ackd_i);
    hit_o[R_STLONG]  = twice[EV_ST];
  end
endmodule

// File: rtl/lspm_sticky.sv
`timescale 1ns/1ps
// Sticky flag bank; clear has priority over a new hit.
module lspm_sticky #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[g] <= 1'b0;
      else if (clr_i)    flag_o[g] <= 1'b0;
      else if (hit_i[g]) flag_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/lsport_monitor.sv
`timescale 1ns/1ps
module lsport_monitor
  import lspm_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               abort_i,
  input  logic               ld_req_i,
  input  logic               st_req_i,
  input  logic               adr_vld_i,
  input  logic [AW-1:0]      adr_i,
  input  logic               adr_ack_i,
  input  logic               adr_exc_i,
  input  logic               ld_vld_i,
  input  logic               st_vld_i,
  output logic               busy_o,
  output logic [N_RULES-1:0] err_o
);
  logic               act, live, kind_st, ackd, held, req_edge;
  logic [AW-1:0]      adr_hold;
  logic [N_EVT-1:0]   evt, evt_prev;
  logic [N_RULES-1:0] hit;

  always_comb begin
    evt         = '0;
    evt[EV_ACK] = adr_ack_i;
    evt[EV_EXC] = adr_exc_i;
    evt[EV_LD]  = ld_vld_i;
    evt[EV_ST]  = st_vld_i;
  end

  lspm_xfer #(.AW(AW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
    .ld_req_i(ld_req_i), .st_req_i(st_req_i),
    .adr_vld_i(adr_vld_i), .adr_i(adr_i),
    .adr_ack_i(adr_ack_i), .adr_exc_i(adr_exc_i),
    .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i),
    .busy_o(busy_o), .act_o(act), .live_o(live), .kind_st_o(kind_st),
    .ackd_o(ackd), .held_o(held), .adr_hold_o(adr_hold),
    .req_edge_o(req_edge)
  );

  lspm_pulse_hist #(.W(N_EVT)) u_hist (
    .clk(clk), .rst_n(rst_n), .cur_i(evt), .prev_o(evt_prev)
  );

  lspm_rules #(.AW(AW)) u_rules (
    .ld_req_i(ld_req_i), .st_req_i(st_req_i), .req_edge_i(req_edge),
    .act_i(act), .live_i(live), .kind_st_i(kind_st), .ackd_i(ackd),
    .held_i(held), .adr_vld_i(adr_vld_i), .adr_i(adr_i),
    .adr_hold_i(adr_hold), .evt_i(evt), .evt_prev_i(evt_prev),
    .hit_o(hit)
  );

  lspm_sticky #(.N(N_RULES)) u_sticky (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .hit_i(hit), .flag_o(err_o)
  );
endmodule

// File: rtl/lspm_monitor_sva.sv
`timescale 1ns/1ps
module lspm_monitor_sva
  import lspm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clr_i,
  input logic               abort_i,
  input logic               ld_req_i,
  input logic               st_req_i,
  input logic               adr_exc_i,
  input logic               ld_vld_i,
  input logic               st_vld_i,
  input logic               busy_o,
  input logic [N_RULES-1:0] err_o
);
  a_r1_both_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req_i && st_req_i && !clr_i) |=> err_o[R_BOTH]);

  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ld_req_i || st_req_i) && !$past(busy_o) && !abort_i &&
     !adr_exc_i && !ld_vld_i) |-> busy_o);

  a_r7_exc_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    adr_exc_i |-> !busy_o);

  a_r9_store_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld_i && busy_o) |=> (!busy_o || $rose(ld_req_i || st_req_i)));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (err_o == '0));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> ((err_o & $past(err_o)) == $past(err_o)));

  a_r11_abort_now: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> !busy_o);

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o || $rose(ld_req_i || st_req_i)));
endmodule

bind lsport_monitor lspm_monitor_sva u_sva (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .abort_i(abort_i),
  .ld_req_i(ld_req_i), .st_req_i(st_req_i), .adr_exc_i(adr_exc_i),
  .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/tb_lsport_monitor.sv
`timescale 1ns/1ps
module tb_lsport_monitor;
  localparam int AW = 8;
  localparam int NR = 10;
  localparam int NV = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_i = 1'b0, abort_i = 1'b0;
  logic          ld_req_i = 1'b0, st_req_i = 1'b0, adr_vld_i = 1'b0;
  logic [AW-1:0] adr_i = '0;
  logic          adr_ack_i = 1'b0, adr_exc_i = 1'b0;
  logic          ld_vld_i = 1'b0, st_vld_i = 1'b0;
  logic          busy_o;
  logic [NR-1:0] err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lsport_monitor #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .abort_i(abort_i),
    .ld_req_i(ld_req_i), .st_req_i(st_req_i), .adr_vld_i(adr_vld_i),
    .adr_i(adr_i), .adr_ack_i(adr_ack_i), .adr_exc_i(adr_exc_i),
    .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i), .busy_o(busy_o), .err_o(err_o)
  );

  // {clr,abort,ld_req,st_req,adr_vld} adr {ack,exc,ld_vld,st_vld} busy err tag
  // err is the sticky vector seen in that cycle (from earlier edges)
  localparam logic [31:0] TBL [NV] = '{
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd12}, // idle
    {5'b00101, 8'h12, 4'b0000, 1'b1, 10'h000, 4'd2},  // R2 load start
    {5'b00101, 8'h12, 4'b1000, 1'b1, 10'h000, 4'd2},
    {5'b00101, 8'h12, 4'b0010, 1'b0, 10'h000, 4'd8},  // R8 ld data drops busy
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd8},
    {5'b00011, 8'h34, 4'b0000, 1'b1, 10'h000, 4'd2},  // store start
    {5'b00011, 8'h34, 4'b1000, 1'b1, 10'h000, 4'd9},
    {5'b00011, 8'h34, 4'b0001, 1'b1, 10'h000, 4'd9},  // R9 busy held in data cycle
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd9},  // R9 low next cycle
    {5'b00101, 8'h56, 4'b0000, 1'b1, 10'h000, 4'd2},
    {5'b00101, 8'h56, 4'b0100, 1'b0, 10'h000, 4'd7},  // R7 exception
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd7},
    {5'b00011, 8'h78, 4'b0001, 1'b1, 10'h000, 4'd9},  // R9 data before accept
    {5'b00011, 8'h78, 4'b0000, 1'b0, 10'h100, 4'd9},
    {5'b10000, 8'h00, 4'b0000, 1'b0, 10'h100, 4'd10}, // R10 clear
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd10},
    {5'b00110, 8'h00, 4'b0000, 1'b1, 10'h000, 4'd1},  // R1 both strobes
    {5'b00000, 8'h00, 4'b0000, 1'b1, 10'h001, 4'd1},
    {5'b00100, 8'h00, 4'b0000, 1'b1, 10'h001, 4'd3},  // R3 edge while active
    {5'b00100, 8'h00, 4'b0100, 1'b0, 10'h003, 4'd3},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h003, 4'd3},
    {5'b10000, 8'h00, 4'b0000, 1'b0, 10'h003, 4'd10},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd10},
    {5'b00101, 8'h10, 4'b0000, 1'b1, 10'h000, 4'd4},
    {5'b00101, 8'h11, 4'b1000, 1'b1, 10'h000, 4'd4},  // R4 address moved
    {5'b00101, 8'h11, 4'b1000, 1'b1, 10'h004, 4'd5},  // R5 accept too long
    {5'b00101, 8'h11, 4'b0010, 1'b0, 10'h00C, 4'd4},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h00C, 4'd5},
    {5'b10000, 8'h00, 4'b0000, 1'b0, 10'h00C, 4'd10},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd10},
    {5'b00011, 8'h20, 4'b0000, 1'b1, 10'h000, 4'd7},
    {5'b00011, 8'h20, 4'b1100, 1'b0, 10'h000, 4'd6},  // R6 accept with exception
    {5'b00011, 8'h20, 4'b0100, 1'b0, 10'h020, 4'd6},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h030, 4'd5},  // R5 exception too long
    {5'b10000, 8'h00, 4'b0000, 1'b0, 10'h030, 4'd10},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd10},
    {5'b00101, 8'h40, 4'b0000, 1'b1, 10'h000, 4'd8},
    {5'b00101, 8'h40, 4'b0010, 1'b0, 10'h000, 4'd8},
    {5'b00101, 8'h40, 4'b0010, 1'b0, 10'h000, 4'd8},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h0C0, 4'd8},  // R8 long + stray
    {5'b10000, 8'h00, 4'b0000, 1'b0, 10'h0C0, 4'd10},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd10},
    {5'b00011, 8'h50, 4'b0000, 1'b1, 10'h000, 4'd9},
    {5'b00011, 8'h50, 4'b1000, 1'b1, 10'h000, 4'd9},
    {5'b00011, 8'h50, 4'b0001, 1'b1, 10'h000, 4'd9},
    {5'b00011, 8'h50, 4'b0001, 1'b0, 10'h000, 4'd9},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h300, 4'd9},  // R9 long + early
    {5'b10000, 8'h00, 4'b0000, 1'b0, 10'h300, 4'd10},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd10},
    {5'b00101, 8'h60, 4'b0000, 1'b1, 10'h000, 4'd11},
    {5'b01101, 8'h60, 4'b0000, 1'b0, 10'h000, 4'd11}, // R11 abort
    {5'b00101, 8'h60, 4'b0000, 1'b0, 10'h000, 4'd11},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd11},
    {5'b00101, 8'h61, 4'b0000, 1'b1, 10'h000, 4'd11}, // restart after abort
    {5'b00101, 8'h61, 4'b0010, 1'b0, 10'h000, 4'd8},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd8},
    {5'b10110, 8'h00, 4'b0000, 1'b1, 10'h000, 4'd10}, // R10 clear beats hit
    {5'b00000, 8'h00, 4'b0000, 1'b1, 10'h000, 4'd10},
    {5'b01000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd11},
    {5'b00000, 8'h00, 4'b0000, 1'b0, 10'h000, 4'd11}
  };

  task automatic drive(input logic [31:0] v);
    clr_i     = v[31];
    abort_i   = v[30];
    ld_req_i  = v[29];
    st_req_i  = v[28];
    adr_vld_i = v[27];
    adr_i     = v[26:19];
    adr_ack_i = v[18];
    adr_exc_i = v[17];
    ld_vld_i  = v[16];
    st_vld_i  = v[15];
  endtask

  task automatic check(input int tag, input int row, input logic busy_x,
                       input logic [NR-1:0] err_x);
    checks++;
    if (busy_o !== busy_x) begin
      fails++;
      $display("FAIL R%0d row %0d busy: got %0b expected %0b", tag, row, busy_o, busy_x);
    end
    checks++;
    if (err_o !== err_x) begin
      fails++;
      $display("FAIL R%0d row %0d err: got %03h expected %03h", tag, row, err_o, err_x);
    end
  endtask

  initial begin
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(12, -1, 1'b0, '0); // R12 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1;
      check(int'(TBL[i][3:0]), i, TBL[i][14], TBL[i][13:4]);
    end
    // R12 reset in mid-transfer with a flag set
    @(negedge clk);
    ld_req_i = 1'b1;
    st_req_i = 1'b1;
    @(negedge clk);
    drive('0);
    #1;
    check(1, 100, 1'b1, 10'h001); // R1 flag seen, transfer active
    rst_n = 1'b0;
    #1;
    check(12, 101, 1'b0, 10'h000); // R12 asynchronous clear
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(12, 102, 1'b0, 10'h000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule